// File: doc/BRIEF.md
# Row-Scheduled Line AIS Stuffing Sequencer

This block steers the justification logic of a 139.264 Mbit/s tributary mapper while a line alarm indication signal (all-ones payload) is being forced and no separate AIS timebase is available. The mapper produces an alarm-rate stream by following a fixed schedule instead of switching clocks. In each 9-row subframe, seven rows take a stuffing opportunity with fixed control-bit and stuff-bit values. The other two rows leave justification to the mapper's normal frequency logic. Throughout, the payload is replaced by ones.

The mapper pulses a row strobe at each row boundary and a subframe-start strobe at the first row of a subframe. The block follows the row position from these strobes. It samples the alarm request and the stuffing-mode select only at row boundaries, so no row is ever partly stuffed. If the selected timing clock is reported lost, all outputs are suppressed at once. A monitor-disable output stays high while stuffed AIS is being produced, so that the receive AIS detector and the frame alignment detector can be held off.

Top module: `ais_stuff_seq`

## Requirements
- R1: While the block is active, `ones_force` is 1. Active means that the latched request and latched mode are both 1 and `tclk_ok` is 1.
- R2: In active rows 1, 2, 3, 4, 6, 7 and 8, `stuff` is 1, all five bits of `cbits` are 1 (5'b11111) and `sbit` is 0.
- R3: In active rows 5 and 9, `stuff` is 0 and `cbits` is 5'b00000, so the mapper justifies normally, but `ones_force` stays 1.
- R4: The latched mode resets to 0. While it is 0, `stuff`, `ones_force`, `mon_off` and `cbits` are all 0, whatever the request.
- R5: When `tclk_ok` is 0, `stuff`, `ones_force`, `mon_off` and `cbits` are 0 in that same cycle.
- R6: `mon_off` equals the active condition of R1.
- R7: A cycle with `sf_start`=1 puts the row position at 1. Otherwise a `row_stb` pulse advances it by one, and row 9 wraps to row 1.
- R8: `ais_req` and `mode_sel` are sampled only in cycles where `row_stb` or `sf_start` is 1. A change between boundaries has no effect on the outputs.
- R9: After reset all outputs are 0, and the row position is 9, so the first row strobe selects row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mapper byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb | input | 1 | One-cycle pulse at each row boundary |
| sf_start | input | 1 | One-cycle pulse at the first row of a subframe |
| ais_req | input | 1 | Request to force line AIS |
| mode_sel | input | 1 | 1 selects row-stuffing AIS, 0 selects the external-clock method |
| tclk_ok | input | 1 | The selected timing clock (drop, add or external) is present |
| stuff | output | 1 | Take the stuffing opportunity in this row |
| cbits | output | 5 | Justification control bit values to insert |
| sbit | output | 1 | Stuff bit value to insert |
| ones_force | output | 1 | Replace payload data by ones |
| mon_off | output | 1 | Hold off the receive AIS and frame alignment detectors |

## Verification
On every cycle the assertions check the following. Stuffed rows always carry all-ones control bits with a zero stuff bit. A lost timing clock silences every output. The row position wraps from 9 to 1 and returns to 1 on each subframe start. The latched request never changes between row boundaries. Only the bench scenarios can show the full row schedule with its two justification rows, the effect of a mid-row request change, resynchronisation partway through a cycle, and the reset-default mode.

// File: rtl/ais_stuff_pkg.sv
package ais_stuff_pkg;
  localparam int unsigned ROWS  = 9;
  localparam int unsigned ROW_W = $clog2(ROWS + 1);
  localparam int unsigned NC    = 5;
  // bit k set: row k+1 is a stuffed row
  localparam logic [ROWS-1:0] STUFF_MAP = 9'b011101111;
  localparam logic S_FILL = 1'b0;

  function automatic logic [ROW_W-1:0] step_row(input logic [ROW_W-1:0] cur,
                                                input logic sync);
    logic [ROW_W-1:0] nxt;
    if (sync) nxt = ROW_W'(1);
    else if (cur >= ROW_W'(ROWS)) nxt = ROW_W'(1);
    else nxt = cur + ROW_W'(1);
    return nxt;
  endfunction

  function automatic logic row_stuffed(input logic [ROW_W-1:0] row);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < ROWS; k++)
      if (row == ROW_W'(k + 1)) hit = STUFF_MAP[k];
    return hit;
  endfunction
endpackage

// File: rtl/ais_row_counter.sv
module ais_row_counter
  import ais_stuff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_stb,
  input  logic             sf_start,
  output logic             boundary,
  output logic [ROW_W-1:0] row_q
);
  assign boundary = row_stb | sf_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= ROW_W'(ROWS);
    else if (boundary) row_q <= step_row(row_q, sf_start);
  end

  a_r7_sync_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    sf_start |=> row_q == ROW_W'(1));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb && !sf_start && row_q == ROW_W'(ROWS)) |=> row_q == ROW_W'(1));
  a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q >= ROW_W'(1) && row_q <= ROW_W'(ROWS));
endmodule

// File: rtl/ais_req_gate.sv
module ais_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic ais_req,
  input  logic mode_sel,
  output logic req_q,
  output logic mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (boundary) begin
      req_q  <= ais_req;
      mode_q <= mode_sel;
    end
  end

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(req_q) && $stable(mode_q));
endmodule

// File: rtl/ais_stuff_encoder.sv
module ais_stuff_encoder
  import ais_stuff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_q,
  input  logic             req_q,
  input  logic             mode_q,
  input  logic             tclk_ok,
  output logic             live,
  output logic             stuff,
  output logic [NC-1:0]    cbits,
  output logic             sbit,
  output logic             ones_force,
  output logic             mon_off
);
  logic row_is_stuff;

  assign live         = req_q & mode_q & tclk_ok;
  assign row_is_stuff = row_stuffed(row_q);

  always_comb begin
    stuff      = live & row_is_stuff;
    cbits      = stuff ? {NC{1'b1}} : {NC{1'b0}};
    sbit       = stuff ? S_FILL : 1'b0;
    ones_force = live;
    mon_off    = live;
  end

  a_r2_stuff_code: assert property (@(posedge clk) disable iff (!rst_n)
    stuff |-> (cbits == {NC{1'b1}} && sbit == 1'b0 && ones_force));
  a_r5_clock_lost: assert property (@(posedge clk) disable iff (!rst_n)
    !tclk_ok |-> (!stuff && !ones_force && !mon_off && cbits == '0));
  a_r4_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (!stuff && !ones_force && !mon_off));
  a_r3_no_stuff_justify: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q == ROW_W'(5) || row_q == ROW_W'(ROWS)) |-> !stuff);
endmodule

// File: rtl/ais_stuff_seq.sv
module ais_stuff_seq
  import ais_stuff_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_stb,
  input  logic          sf_start,
  input  logic          ais_req,
  input  logic          mode_sel,
  input  logic          tclk_ok,
  output logic          stuff,
  output logic [NC-1:0] cbits,
  output logic          sbit,
  output logic          ones_force,
  output logic          mon_off
);
  logic             boundary;
  logic [ROW_W-1:0] row_q;
  logic             req_q;
  logic             mode_q;
  logic             live;

  ais_row_counter u_rows (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .sf_start(sf_start),
    .boundary(boundary), .row_q(row_q)
  );

  ais_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .ais_req(ais_req),
    .mode_sel(mode_sel), .req_q(req_q), .mode_q(mode_q)
  );

  ais_stuff_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .row_q(row_q), .req_q(req_q), .mode_q(mode_q),
    .tclk_ok(tclk_ok), .live(live), .stuff(stuff), .cbits(cbits),
    .sbit(sbit), .ones_force(ones_force), .mon_off(mon_off)
  );

  a_r6_monitor_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    mon_off == live);
  a_r1_ones_when_live: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ones_force);
endmodule

// File: tb/ais_stuff_seq_bench.sv
module ais_stuff_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // [12]sf [11]req [10]mode [9]ok | [8]stuff [7]ones [6]mon [5:1]cbits [0]sbit
  localparam logic [12:0] VEC [NV] = '{
    13'b1111_111111110, 13'b0111_111111110, 13'b0111_111111110,
    13'b0111_111111110, 13'b0111_011000000, 13'b0111_111111110,
    13'b0111_111111110, 13'b0111_111111110, 13'b0111_011000000,
    13'b0111_111111110, 13'b0011_000000000, 13'b0101_000000000,
    13'b0110_000000000, 13'b0111_011000000, 13'b1111_111111110,
    13'b0111_111111110
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb = 1'b0, sf_start = 1'b0, ais_req = 1'b0, mode_sel = 1'b0;
  logic tclk_ok = 1'b1;
  logic stuff, sbit, ones_force, mon_off;
  logic [4:0] cbits;
  int checks = 0;
  int errors = 0;
  logic [8:0] held;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ais_stuff_seq u_ais_stuff_seq (
    .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .sf_start(sf_start),
    .ais_req(ais_req), .mode_sel(mode_sel), .tclk_ok(tclk_ok),
    .stuff(stuff), .cbits(cbits), .sbit(sbit), .ones_force(ones_force),
    .mon_off(mon_off)
  );

  function automatic logic [8:0] outs();
    return {stuff, ones_force, mon_off, cbits, sbit};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic row_step(input logic sf, input logic req, input logic md, input logic ok);
    @(negedge clk);
    row_stb = 1'b1; sf_start = sf; ais_req = req; mode_sel = md; tclk_ok = ok;
    @(negedge clk);
    row_stb = 1'b0; sf_start = 1'b0;
  endtask

  function automatic string tag_of(input int i);
    logic [12:0] v;
    v = VEC[i];
    if (i == 9 || i == 14) return "R7 resync/wrap";
    if (!v[10]) return "R4 mode off";
    if (!v[9])  return "R5 clock lost";
    if (!v[11]) return "R8 request sampled";
    if (v[8])   return "R2 stuffed row";
    return "R3 justification row";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", outs(), 9'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", outs(), 9'b0);

    // R4: reset-default mode does nothing even with request held
    ais_req = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 default mode inactive", outs(), 9'b0);

    for (int i = 0; i < NV; i++) begin
      row_step(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check(tag_of(i), outs(), VEC[i][8:0]);
    end
    // entry 15 left the block active in row 2
    check("R6 monitor disable while active", {8'b0, mon_off}, 9'd1);
    check("R1 ones forced while active", {8'b0, ones_force}, 9'd1);

    // R8: mid-row request drop must not change the row
    held = outs();
    ais_req = 1'b0; mode_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 mid-row change ignored", outs(), held);
    row_step(1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 change applied at boundary", outs(), 9'b0);

    // R5: clock loss within a stuffed row silences outputs same cycle
    row_step(1'b1, 1'b1, 1'b1, 1'b1);
    check("R2 stuffed row1", outs(), 9'b111111110);
    tclk_ok = 1'b0;
    #1;
    check("R5 clock lost immediate", outs(), 9'b0);
    tclk_ok = 1'b1;
    #1;
    check("R5 clock restored", outs(), 9'b111111110);

    // R9: reset mid-run returns row to 9, first strobe gives row 1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears outputs", outs(), 9'b0);
    rst_n = 1'b1;
    row_step(1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 first strobe selects row 1", outs(), 9'b111111110);
    repeat (4) row_step(1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 row 5 after reset", outs(), 9'b011000000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule